// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial bus slave (SMBus/I2C compatible, standard mode) that keeps a bank of seventeen 8-bit configuration registers for the rest of the chip. A fast system clock oversamples the bus lines through a two-stage synchronizer. Edge detection on the synchronized lines finds START, STOP and clock edges. The slave drives the data line only through an open-drain enable and never stretches the clock. All seventeen registers are presented in parallel on a flat output bus.

Only block transfers are supported. A write carries the write address, then a command byte and a byte count. Both are acknowledged and discarded. After them come data bytes, which load into register 0, 1, 2 and upward in order until the host ends with STOP. A read carries the read address. The slave then returns the content of the count register, followed by registers 0 upward, for as long as the host acknowledges. Register 8 sets the last readable index. Two register pairs (11 with 12, and 13 with 14) only change together, so a setting split over a pair cannot be left half-written.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read). It does not pull SDA low in the acknowledge slot of any other address, and that transaction changes no register.
- R2: In a write, the first two bytes after the address are acknowledged and have no effect on any register. Every following data byte is also acknowledged.
- R3: Data byte k of a write (k = 0, 1, ...) loads register k. A STOP after any complete byte keeps every byte already received.
- R4: Registers 11 and 12 update together only when the byte for register 12 arrives. Registers 13 and 14 work the same way. A transfer that stops after register 11 or 13 leaves that pair unchanged.
- R5: A write of 0x00 to register 8 (the read count) is ignored. Any non-zero value is stored.
- R6: Registers 6 (device identity, default 0x21) and 7 (revision, default 0x0C) are read-only. Data bytes that would land past register 16 are acknowledged and discarded.
- R7: A read returns register 8 first, then register 0 upward. Any index above the value of register 8 or above 16 returns 0xFF. After the host sends a NACK, the slave releases SDA for the rest of the transfer.
- R8: After reset, registers 1 to 3 hold 0xFF, register 4 holds 0x10, register 8 holds 0x08, and registers 6 and 7 hold their identity values. All other registers hold 0x00.
- R9: The slave changes its SDA drive only after a falling SCL edge. It drives nothing once a STOP has been seen.
- R10: A repeated START restarts address decoding, so a write may be followed directly by a read of the updated registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, loads defaults |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_o | output | 136 | All registers, register n in bits [8n+7:8n] |

## Verification
Some properties hold on every cycle and are checked by the assertions. The drive enable only rises after a detected SCL fall and is low after a STOP. The read count never becomes zero. Each paired register changes only in the cycle after the second byte of its pair completes. The parallel bus changes only while data is being received, and a NACK returns the slave to idle with SDA released. Other behaviour only shows through whole transactions: which register a given data byte lands in, discarding a half-written pair, the 0xFF padding past the count, and the repeated-START turnaround. The bench checks these by sweeping write lengths across every register boundary and reading back against a model of the requirements.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         NREG     = 17,
  parameter logic [7:0] DEV_ID   = 8'h21,
  parameter logic [7:0] REV_ID   = 8'h0C,
  parameter logic [7:0] CNT_DEF  = 8'h08,
  parameter logic [7:0] WDT_DEF  = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int AW   = $clog2(NREG);
  localparam int IDXW = AW + 1;
  localparam logic [IDXW-1:0] LAST    = IDXW'(NREG - 1);
  localparam logic [IDXW-1:0] IX_DEV  = IDXW'(6);
  localparam logic [IDXW-1:0] IX_REV  = IDXW'(7);
  localparam logic [IDXW-1:0] IX_CNT  = IDXW'(8);
  localparam logic [IDXW-1:0] IX_A1   = IDXW'(11);
  localparam logic [IDXW-1:0] IX_A2   = IDXW'(12);
  localparam logic [IDXW-1:0] IX_B1   = IDXW'(13);
  localparam logic [IDXW-1:0] IX_B2   = IDXW'(14);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WRX, S_WACK, S_RTX, S_RACK} st_t;

  st_t             st;
  logic            scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [7:0]      sh, txsh, stage_a, stage_b, rd_b;
  logic [3:0]      bitcnt;
  logic [1:0]      hdr;
  logic [IDXW-1:0] widx, ridx;
  logic            rw, nack;
  logic [7:0]      regs [NREG];

  function automatic logic [7:0] def_val(input int i);
    case (i)
      1, 2, 3: def_val = 8'hFF;
      4:       def_val = WDT_DEF;
      6:       def_val = DEV_ID;
      7:       def_val = REV_ID;
      8:       def_val = CNT_DEF;
      default: def_val = 8'h00;
    endcase
  endfunction

  wire rise_c  = scl_s & ~scl_q;
  wire fall_c  = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  assign sda_oe = (st == S_AACK) | (st == S_WACK) | ((st == S_RTX) & ~txsh[7]);

  always_comb begin
    if (ridx > LAST || 8'(ridx) > regs[AW'(IX_CNT)]) rd_b = 8'hFF;
    else rd_b = regs[ridx[AW-1:0]];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= '1;
      st <= S_IDLE;
      sh <= '0;  txsh <= '1;  stage_a <= '0;  stage_b <= '0;
      bitcnt <= '0;  hdr <= '0;  widx <= '0;  ridx <= '0;
      rw <= 1'b0;  nack <= 1'b1;
      for (int i = 0; i < NREG; i++) regs[i] <= def_val(i);
    end else begin
      scl_m <= scl_i;  scl_s <= scl_m;  scl_q <= scl_s;
      sda_m <= sda_i;  sda_s <= sda_m;  sda_q <= sda_s;
      if (start_c) begin
        st <= S_ADDR;  bitcnt <= '0;  hdr <= '0;  widx <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else if (rise_c) begin
        case (st)
          S_ADDR, S_WRX: if (bitcnt != 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          S_RTX:  if (bitcnt != 4'd8) bitcnt <= bitcnt + 4'd1;
          S_RACK: nack <= sda_s;
          default: ;
        endcase
      end else if (fall_c) begin
        case (st)
          S_ADDR: if (bitcnt == 4'd8) begin
            if (sh[7:1] == SLV_ADDR) begin
              st <= S_AACK;  rw <= sh[0];
            end else st <= S_IDLE;
          end
          S_AACK: begin
            bitcnt <= '0;
            if (rw) begin
              st <= S_RTX;  txsh <= regs[AW'(IX_CNT)];  ridx <= '0;
            end else st <= S_WRX;
          end
          S_WRX: if (bitcnt == 4'd8) begin
            st <= S_WACK;
            if (hdr != 2'd2) hdr <= hdr + 2'd1;
            else begin
              if (widx != '1) widx <= widx + 1'b1;
              if (widx <= LAST) begin
                case (widx)
                  IX_DEV, IX_REV: ;
                  IX_CNT: if (sh != 8'h00) regs[AW'(IX_CNT)] <= sh;
                  IX_A1:  stage_a <= sh;
                  IX_A2:  begin regs[AW'(IX_A1)] <= stage_a; regs[AW'(IX_A2)] <= sh; end
                  IX_B1:  stage_b <= sh;
                  IX_B2:  begin regs[AW'(IX_B1)] <= stage_b; regs[AW'(IX_B2)] <= sh; end
                  default: regs[widx[AW-1:0]] <= sh;
                endcase
              end
            end
          end
          S_WACK: begin st <= S_WRX;  bitcnt <= '0; end
          S_RTX: begin
            if (bitcnt == 4'd8) st <= S_RACK;
            else txsh <= {txsh[6:0], 1'b1};
          end
          S_RACK: begin
            if (nack) st <= S_IDLE;
            else begin
              st <= S_RTX;  bitcnt <= '0;  txsh <= rd_b;
              if (ridx != '1) ridx <= ridx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> $past(fall_c)); // R9
  AST_QUIET_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n) $past(stop_c) |-> !sda_oe); // R9
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) regs[AW'(IX_CNT)] != 8'h00); // R5
  AST_PAIR_A_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[AW'(IX_A1)]) |-> $past(fall_c && st == S_WRX && hdr == 2'd2 && widx == IX_A2)); // R4
  AST_PAIR_B_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs[AW'(IX_B1)]) |-> $past(fall_c && st == S_WRX && hdr == 2'd2 && widx == IX_B2)); // R4
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg_o) |-> $past(st == S_WRX)); // R3
  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && fall_c && nack) |=> (st == S_IDLE && !sda_oe)); // R7
endmodule

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int NR = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic oe;
  logic [NR*8-1:0] cfg;
  wire sda_w = host_sda & ~oe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] expr [NR];
  logic [7:0] wbuf [24];
  logic [7:0] pend_a, pend_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe(oe), .cfg_o(cfg));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    bit ok = 1'b1;
    logic [31:0] a = 0, e = 0;
    for (int i = 0; i < NR; i++)
      if (ok && cfg[i*8 +: 8] !== expr[i]) begin
        ok = 1'b0; a = {16'(i), 8'h0, cfg[i*8 +: 8]}; e = {16'(i), 8'h0, expr[i]};
      end
    chk(ok, tag, a, e);
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    host_sda = 1'b1; hq(); scl = 1'b1; hq(); host_sda = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hq(); scl = 1'b1; hq(); host_sda = 1'b1; hq();
  endtask

  task automatic wbit(input logic b);
    host_sda = b; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
  endtask

  task automatic rbit(output logic b);
    host_sda = 1'b1; hq(); scl = 1'b1; hq(); b = sda_w; hq(); scl = 1'b0; hq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nak);
  endtask

  task automatic rbyte(input bit last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(last);
  endtask

  function automatic logic [7:0] rd_exp(input int i);
    int idx = i - 1;
    if (i == 0) return expr[8];
    if (idx > NR - 1 || idx > int'(expr[8])) return 8'hFF;
    return expr[idx];
  endfunction

  task automatic model_write(input int n);
    for (int k = 0; k < n; k++) begin
      case (k)
        6, 7: ;
        8:  if (wbuf[k] != 8'h00) expr[8] = wbuf[k];
        11: pend_a = wbuf[k];
        12: begin expr[11] = pend_a; expr[12] = wbuf[k]; end
        13: pend_b = wbuf[k];
        14: begin expr[13] = pend_b; expr[14] = wbuf[k]; end
        default: if (k < NR) expr[k] = wbuf[k];
      endcase
    end
  endtask

  task automatic send_write(input int n, input logic [7:0] cmd, input logic [7:0] cnt, output bit allack);
    logic a;
    allack = 1'b1;
    wbyte(8'hD2, a); if (a) allack = 1'b0;
    wbyte(cmd, a);   if (a) allack = 1'b0;
    wbyte(cnt, a);   if (a) allack = 1'b0;
    for (int k = 0; k < n; k++) begin wbyte(wbuf[k], a); if (a) allack = 1'b0; end
  endtask

  task automatic do_write(input int n, input logic [7:0] cmd, input logic [7:0] cnt, input string tag);
    bit allack;
    bus_start();
    send_write(n, cmd, cnt, allack);
    bus_stop();
    chk(allack, "R2 every write byte acknowledged", {31'h0, ~allack}, 0);
    model_write(n);
    chk_regs(tag);
  endtask

  task automatic read_body(input int n, input string tag);
    logic a;
    logic [7:0] d;
    bit ok = 1'b1;
    logic [31:0] av = 0, ev = 0;
    wbyte(8'hD3, a);
    chk(a == 1'b0, "R1 read address acknowledged", {31'h0, a}, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d);
      if (ok && d !== rd_exp(i)) begin ok = 1'b0; av = {16'(i), 8'h0, d}; ev = {16'(i), 8'h0, rd_exp(i)}; end
    end
    chk(ok, tag, av, ev);
  endtask

  task automatic do_read(input int n, input string tag);
    bus_start();
    read_body(n, tag);
    hq();
    chk(oe == 1'b0, "R7 released after host NACK", {31'h0, oe}, 0);
    bus_stop();
    chk(oe == 1'b0, "R9 no drive after STOP", {31'h0, oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    bit allack;
    int lens [11] = '{1, 2, 5, 8, 11, 12, 13, 14, 15, 17, 20};
    for (int i = 0; i < NR; i++) expr[i] = 8'h00;
    expr[1] = 8'hFF; expr[2] = 8'hFF; expr[3] = 8'hFF; expr[4] = 8'h10;
    expr[6] = 8'h21; expr[7] = 8'h0C; expr[8] = 8'h08;
    pend_a = 8'h00; pend_b = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_regs("R8 power-on defaults");
    chk(oe == 1'b0, "R9 idle bus not driven", {31'h0, oe}, 0);

    do_read(22, "R7 default readback with 0xFF padding");

    bus_start();
    wbyte(8'hD4, a);
    chk(a == 1'b1, "R1 foreign write address not acknowledged", {31'h0, a}, 1);
    wbyte(8'h00, a); wbyte(8'h00, a); wbyte(8'h5A, a);
    bus_stop();
    chk_regs("R1 foreign address leaves registers");
    bus_start();
    wbyte(8'h53, a);
    chk(a == 1'b1, "R1 foreign read address not acknowledged", {31'h0, a}, 1);
    bus_stop();

    foreach (lens[j]) begin
      for (int k = 0; k < 24; k++) wbuf[k] = 8'(lens[j] * 29 + k * 53 + 1);
      do_write(lens[j], 8'(lens[j]), 8'(~lens[j]), "R3 R4 sequential load and pair commit");
    end

    for (int k = 0; k < 24; k++) wbuf[k] = 8'(k * 17 + 5);
    wbuf[8] = 8'h00;
    do_write(9, 8'hFF, 8'h09, "R5 zero count write ignored");
    chk(cfg[8*8 +: 8] == expr[8], "R5 count kept", 32'(cfg[8*8 +: 8]), 32'(expr[8]));

    wbuf[6] = 8'hEE; wbuf[7] = 8'hDD; wbuf[8] = 8'h03;
    do_write(20, 8'h00, 8'h00, "R6 read-only identity and overflow ignored");
    chk(cfg[6*8 +: 16] == 16'h0C21, "R6 identity bytes", 32'(cfg[6*8 +: 16]), 32'h0C21);
    do_read(10, "R7 short count pads with 0xFF");

    for (int k = 0; k < 24; k++) wbuf[k] = 8'(k * 91 + 7);
    wbuf[8] = 8'h20;
    do_write(15, 8'h11, 8'h22, "R4 both pairs committed");
    do_read(21, "R7 count past last register");

    for (int k = 0; k < 24; k++) wbuf[k] = 8'(k + 8'hC0);
    bus_start();
    send_write(2, 8'h33, 8'h02, allack);
    chk(allack, "R10 write before repeated start acknowledged", {31'h0, ~allack}, 0);
    model_write(2);
    bus_start();
    read_body(4, "R10 repeated start readback");
    bus_stop();
    chk_regs("R10 registers after turnaround");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule